// File: doc/BRIEF.md
# Double-Buffered DAC Update Timer

This block is the register and timing front end of a 10-bit digital-to-analog converter. A small register bus reaches three registers: a sample register that holds the 10-bit output code and a settling-mode select bit, a control register, and a 16-bit reload register. The block drives the live sample code and the settling-mode bit straight into the analog converter. The analog output is nominally code × VREF / 1024.

A down-counter runs on the peripheral clock. Each time it expires, it reloads and raises a request flag. This flag serves as an interrupt request and, when enabled, as a DMA request. When double-buffering is on, a bus write to the sample register fills a hidden staging register at the same address. The live sample is replaced from the staging register only on counter expiry, so periodic sample updates carry no jitter from the bus. When double-buffering is off, bus writes land on the live sample at once.

Top module: `dac_update_timer`

## Requirements
- R1: After reset, sample_o, bias_o, req_o and dma_req_o are 0, and reads at addresses 0, 1 and 2 all return 0.
- R2: Address 0 holds the sample register: the code is in bits [9:0] and the settling-mode bit is bit 10; all other bits are ignored. With double-buffering off, a write there shows on sample_o/bias_o one cycle after the write edge.
- R3: With double-buffering on, a write to address 0 loads only the staging register; sample_o and bias_o do not change until the next expiry.
- R4: On an expiry with double-buffering on, the live sample takes the staging register value. The new value is visible after that expiry edge.
- R5: Address 2 holds the reload value in bits [15:0]. With counting enabled, the counter steps down once per clock and expires every reload+1 cycles. The first expiry comes at the (reload+1)th edge after the edge that enables counting, and each expiry sets the request flag.
- R6: The request flag is cleared by a write to address 0. The flag bit in a control write is ignored.
- R7: A reload value of 0 makes the counter expire on every clock while counting is enabled, so the flag stays set even across sample writes.
- R8: A read of address 0 returns the live sample, never the staging register.
- R9: With counting disabled the counter never expires. The flag stays clear, and the counter holds the reload value.
- R10: Address 1 holds the control register: bit0 = request flag (read only), bit1 = double-buffer enable, bit2 = count enable, bit3 = DMA enable. The output dma_req_o is the flag gated by bit3, and req_o is the flag itself.
- R11: When a sample write and an expiry fall on the same edge, the flag ends set. The live sample takes the old staging value, and the written value is committed at the following expiry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | peripheral clock |
| rst_ni | input | 1 | active-low asynchronous reset |
| req_i | input | 1 | bus access strobe |
| we_i | input | 1 | write enable for the access |
| addr_i | input | 2 | register address (0 sample, 1 control, 2 reload) |
| wdata_i | input | 32 | write data |
| rdata_o | output | 32 | read data, combinational from addr_i |
| sample_o | output | 10 | live sample code to the converter |
| bias_o | output | 1 | settling-mode select to the converter |
| req_o | output | 1 | request flag |
| dma_req_o | output | 1 | request flag gated by DMA enable |

## Verification
A register write lands on the clock edge that samples it. Its effect on sample_o, bias_o, req_o and read data is due one cycle later, and the bench samples 1 ns after that edge. An expiry is due at the (reload+1)th edge after the enabling write, and again every reload+1 edges after that. The bench counts edges from the write task's return and samples right after the expected expiry edge and right before it. Collisions are lined up by timing a sample write onto a computed expiry edge.

// File: rtl/dac_ut_pkg.sv
package dac_ut_pkg;
  localparam int unsigned CODE_W = 10;
  localparam int unsigned CNT_W  = 16;
  localparam int unsigned BIAS_BIT = CODE_W;

  localparam logic [1:0] ADDR_SAMPLE = 2'd0;
  localparam logic [1:0] ADDR_CTRL   = 2'd1;
  localparam logic [1:0] ADDR_RELOAD = 2'd2;

  localparam int unsigned CTRL_FLAG = 0;
  localparam int unsigned CTRL_DBL  = 1;
  localparam int unsigned CTRL_CNT  = 2;
  localparam int unsigned CTRL_DMA  = 3;

  typedef struct packed {
    logic              bias;
    logic [CODE_W-1:0] code;
  } sample_t;
endpackage

// File: rtl/dac_ut_counter.sv
module dac_ut_counter
  import dac_ut_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cnt_en_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!cnt_en_i)         cnt_q <= reload_i;
    else if (cnt_q == '0)       cnt_q <= reload_i;
    else                        cnt_q <= cnt_q - 1'b1;
  end

  assign expire_o = cnt_en_i && (cnt_q == '0);

  p_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_en_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
  p_reload_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o |=> (cnt_q == $past(reload_i)));
  p_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cnt_en_i |=> (cnt_q == $past(reload_i)));
endmodule

// File: rtl/dac_ut_sample.sv
module dac_ut_sample
  import dac_ut_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    wr_i,
  input  sample_t wr_val_i,
  input  logic    dbl_en_i,
  input  logic    expire_i,
  output sample_t live_o
);
  sample_t stage_q, live_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   stage_q <= '0;
    else if (wr_i) stage_q <= wr_val_i;
  end

  // direct write and buffered commit are exclusive by dbl_en_i
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  live_q <= '0;
    else if (wr_i && !dbl_en_i)   live_q <= wr_val_i;
    else if (dbl_en_i && expire_i) live_q <= stage_q;
  end

  assign live_o = live_q;

  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dbl_en_i && !expire_i) |=> $stable(live_q));
  p_commit_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dbl_en_i && expire_i) |=> (live_q == $past(stage_q)));
  p_direct_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !dbl_en_i) |=> (live_q == $past(wr_val_i)));
endmodule

// File: rtl/dac_ut_regs.sv
module dac_ut_regs
  import dac_ut_pkg::*;
#(
  parameter int unsigned DW = 32,
  parameter int unsigned AW = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             we_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    rdata_o,
  input  logic             expire_i,
  input  sample_t          live_i,
  output logic             smp_wr_o,
  output sample_t          smp_val_o,
  output logic             dbl_en_o,
  output logic             cnt_en_o,
  output logic             dma_en_o,
  output logic             flag_o,
  output logic [CNT_W-1:0] reload_o
);
  localparam int unsigned SMP_W = CODE_W + 1;

  logic wr_smp, wr_ctrl, wr_rld;
  logic dbl_q, cnt_q, dma_q, flag_q;
  logic [CNT_W-1:0] reload_q;
  logic unused_wdata;

  assign wr_smp  = req_i && we_i && (addr_i == AW'(ADDR_SAMPLE));
  assign wr_ctrl = req_i && we_i && (addr_i == AW'(ADDR_CTRL));
  assign wr_rld  = req_i && we_i && (addr_i == AW'(ADDR_RELOAD));
  assign unused_wdata = ^wdata_i[DW-1:SMP_W] ^ wdata_i[CTRL_FLAG];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dbl_q <= 1'b0;
      cnt_q <= 1'b0;
      dma_q <= 1'b0;
    end else if (wr_ctrl) begin
      dbl_q <= wdata_i[CTRL_DBL];
      cnt_q <= wdata_i[CTRL_CNT];
      dma_q <= wdata_i[CTRL_DMA];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     reload_q <= '0;
    else if (wr_rld) reload_q <= wdata_i[CNT_W-1:0];
  end

  // expiry wins over the clearing write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       flag_q <= 1'b0;
    else if (expire_i) flag_q <= 1'b1;
    else if (wr_smp)   flag_q <= 1'b0;
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      AW'(ADDR_SAMPLE): rdata_o[SMP_W-1:0] = live_i;
      AW'(ADDR_CTRL): begin
        rdata_o[CTRL_FLAG] = flag_q;
        rdata_o[CTRL_DBL]  = dbl_q;
        rdata_o[CTRL_CNT]  = cnt_q;
        rdata_o[CTRL_DMA]  = dma_q;
      end
      AW'(ADDR_RELOAD): rdata_o[CNT_W-1:0] = reload_q;
      default: rdata_o = '0;
    endcase
  end

  assign smp_wr_o  = wr_smp;
  assign smp_val_o = wdata_i[SMP_W-1:0];
  assign dbl_en_o  = dbl_q;
  assign cnt_en_o  = cnt_q;
  assign dma_en_o  = dma_q;
  assign flag_o    = flag_q;
  assign reload_o  = reload_q;

  p_flag_set_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_i |=> flag_q);
  p_flag_clr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_smp && !expire_i) |=> !flag_q);
  p_flag_keep_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_smp && !expire_i) |=> (flag_q == $past(flag_q)));
endmodule

// File: rtl/dac_update_timer.sv
module dac_update_timer
  import dac_ut_pkg::*;
#(
  parameter int unsigned DW = 32,
  parameter int unsigned AW = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  output logic [CODE_W-1:0] sample_o,
  output logic              bias_o,
  output logic              req_o,
  output logic              dma_req_o
);
  logic             expire, smp_wr, dbl_en, cnt_en, dma_en, flag;
  logic [CNT_W-1:0] reload;
  sample_t          smp_val, live;

  dac_ut_regs #(.DW(DW), .AW(AW)) u_regs (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i, .rdata_o,
    .expire_i (expire),
    .live_i   (live),
    .smp_wr_o (smp_wr),
    .smp_val_o(smp_val),
    .dbl_en_o (dbl_en),
    .cnt_en_o (cnt_en),
    .dma_en_o (dma_en),
    .flag_o   (flag),
    .reload_o (reload)
  );

  dac_ut_counter u_cnt (
    .clk_i, .rst_ni,
    .cnt_en_i(cnt_en),
    .reload_i(reload),
    .expire_o(expire)
  );

  dac_ut_sample u_smp (
    .clk_i, .rst_ni,
    .wr_i    (smp_wr),
    .wr_val_i(smp_val),
    .dbl_en_i(dbl_en),
    .expire_i(expire),
    .live_o  (live)
  );

  assign sample_o  = live.code;
  assign bias_o    = live.bias;
  assign req_o     = flag;
  assign dma_req_o = flag && dma_en;

  p_dma_gate_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_req_o |-> (req_o && dma_en));
  p_no_expire_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cnt_en |-> !expire);
endmodule

// File: tb/dac_update_timer_bench.sv
`timescale 1ns/1ps
module dac_update_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [9:0]  sample;
  logic        bias, rq, dma_rq;
  int total = 0, bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dac_update_timer u_dac_update_timer (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .sample_o(sample), .bias_o(bias),
    .req_o(rq), .dma_req_o(dma_rq)
  );

  localparam int NV = 6;
  localparam logic [31:0] V_DATA [NV] = '{32'h0000_03FF, 32'h0000_0400, 32'h0000_07FF,
                                          32'hFFFF_F800, 32'h0000_0155, 32'h0000_06AA};
  localparam logic [9:0]  V_CODE [NV] = '{10'h3FF, 10'h000, 10'h3FF, 10'h000, 10'h155, 10'h2AA};
  localparam logic        V_BIAS [NV] = '{1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1};

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // write lands on the next posedge; returns 1 ns after it
  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    addr = a; #0.2; d = rdata;
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    logic [31:0] r;
    #3; rst_n = 1'b1;
    step(1);
    // R1 reset state
    chk("R1 sample", {22'd0, sample}, 32'h0);
    chk("R1 bias", {31'd0, bias}, 32'h0);
    chk("R1 req", {31'd0, rq}, 32'h0);
    chk("R1 dma", {31'd0, dma_rq}, 32'h0);
    rd(2'd0, r); chk("R1 rd0", r, 32'h0);
    rd(2'd1, r); chk("R1 rd1", r, 32'h0);
    rd(2'd2, r); chk("R1 rd2", r, 32'h0);

    // R2 direct mode vector table
    for (int i = 0; i < NV; i++) begin
      wr(2'd0, V_DATA[i]);
      chk("R2 code", {22'd0, sample}, {22'd0, V_CODE[i]});
      chk("R2 bias", {31'd0, bias}, {31'd0, V_BIAS[i]});
      rd(2'd0, r); chk("R2 rd", r, {21'd0, V_BIAS[i], V_CODE[i]});
      chk("R9 no flag", {31'd0, rq}, 32'h0);
    end

    // R3/R8/R9 buffered, counter off
    wr(2'd2, 32'hABCD_0003);
    rd(2'd2, r); chk("R5 reload rd", r, 32'h0000_0003);
    wr(2'd1, 32'h2);
    wr(2'd0, 32'h555);          // staging: bias1 code 155
    step(10);
    chk("R3 held", {22'd0, sample}, 32'h2AA);
    chk("R3 bias held", {31'd0, bias}, 32'h1);
    rd(2'd0, r); chk("R8 rd live", r, 32'h6AA);
    chk("R9 idle flag", {31'd0, rq}, 32'h0);

    // R5/R4/R6/R10 counting, reload 3
    wr(2'd1, 32'hF);            // E0; flag bit ignored
    chk("R6 ctrl flag ignored", {31'd0, rq}, 32'h0);
    step(3);                    // E3
    chk("R5 before expiry", {31'd0, rq}, 32'h0);
    chk("R3 before commit", {22'd0, sample}, 32'h2AA);
    step(1);                    // E4
    chk("R5 expiry", {31'd0, rq}, 32'h1);
    chk("R10 dma", {31'd0, dma_rq}, 32'h1);
    chk("R4 commit", {22'd0, sample}, 32'h155);
    chk("R4 commit bias", {31'd0, bias}, 32'h1);
    rd(2'd1, r); chk("R10 ctrl rd", r, 32'hF);
    wr(2'd0, 32'h0AA);          // E5
    chk("R6 clear", {31'd0, rq}, 32'h0);
    chk("R3 write buffered", {22'd0, sample}, 32'h155);
    step(2);                    // E7
    chk("R5 period pre", {31'd0, rq}, 32'h0);
    step(1);                    // E8
    chk("R5 period", {31'd0, rq}, 32'h1);
    chk("R4 second commit", {22'd0, sample}, 32'h0AA);
    chk("R4 second bias", {31'd0, bias}, 32'h0);

    // R11 collision at E12
    step(3);                    // E11
    wr(2'd0, 32'h3C3);          // E12
    chk("R11 flag", {31'd0, rq}, 32'h1);
    chk("R11 old stage", {22'd0, sample}, 32'h0AA);
    step(4);                    // E16
    chk("R11 new commit", {22'd0, sample}, 32'h3C3);

    // R7 reload zero
    wr(2'd1, 32'h2);            // counter off
    wr(2'd0, 32'h001);
    chk("R6 clear2", {31'd0, rq}, 32'h0);
    wr(2'd2, 32'h0);
    wr(2'd1, 32'h6);            // E0
    step(1);
    chk("R7 first", {31'd0, rq}, 32'h1);
    chk("R7 commit", {22'd0, sample}, 32'h001);
    chk("R10 dma off", {31'd0, dma_rq}, 32'h0);
    wr(2'd0, 32'h002);
    chk("R7 write no clear", {31'd0, rq}, 32'h1);
    step(1);
    chk("R7 commit each", {22'd0, sample}, 32'h002);
    for (int k = 0; k < 4; k++) begin
      step(1);
      chk("R7 steady", {31'd0, rq}, 32'h1);
    end
    rd(2'd1, r); chk("R10 ctrl rd2", r, 32'h7);

    // R9/R6 stop counting: flag persists until a write
    wr(2'd1, 32'h0);
    step(3);
    chk("R9 flag kept", {31'd0, rq}, 32'h1);
    wr(2'd0, 32'h7FE);
    chk("R6 clear3", {31'd0, rq}, 32'h0);
    chk("R2 direct again", {22'd0, sample}, 32'h3FE);
    step(5);
    chk("R9 stays clear", {31'd0, rq}, 32'h0);

    // R1 async reset mid-run
    wr(2'd1, 32'hE);
    step(2);
    rst_n = 1'b0; #1;
    chk("R1 reset sample", {22'd0, sample}, 32'h0);
    rd(2'd1, r); chk("R1 reset ctrl", r, 32'h0);
    rst_n = 1'b1;

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #50000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule